// File: doc/BRIEF.md
# Priority Restart-Vector Interrupt Encoder

The block watches eight active-low interrupt request lines from peripheral ports and resolves them with fixed priority, in which a higher line number always beats a lower one. While any line is pulled low it raises one active-high interrupt line toward the processor. Each line is a separate priority level, and the index of the highest pending level is a 3-bit code.

When the processor acknowledges, the block turns that code into a one-byte RESTART opcode. It drives the byte onto the data bus only while both acknowledge and data-bus-in are true. The code is captured in the first clock cycle in which acknowledge is seen high. It stays fixed for the whole acknowledge, so a late request cannot change the byte that is on the bus.

The byte has no valid/ready handshake and cannot be held back by the processor. The bus enable acts as the only qualifier, and the processor takes the byte in whichever cycle the enable is high. Clearing requests is left to the peripherals.

Top module: `rstvec_encoder`

## Requirements
- R1: `int_req` is high in the clock cycle after any `irq_n` bit is sampled low. Request lines are registered once, so there is one cycle of latency.
- R2: `int_req` is low one cycle after all eight `irq_n` bits are sampled high.
- R3: The winning level is the highest index `i` whose `irq_n[i]` is low. With no line low the code is 0.
- R4: The driven byte is binary `11 NNN 111`, where NNN is the winning level. Examples: level 0 gives 0xC7, level 2 gives 0xD7, level 7 gives 0xFF.
- R5: `vec_oe` is high exactly while both `inta` and `dbin` are high. It follows those inputs in the same cycle, with no register in the path.
- R6: Whenever `vec_oe` is low, `vec_data` reads 0x00. This holds even with `dbin` high and no acknowledge.
- R7: The level is taken in the cycle in which `inta` is first seen high. The byte is then held for as long as `inta` stays high, whatever the request lines do.
- R8: During reset (`rst_n` low) `int_req` is low, and with `inta` low `vec_oe` is low and `vec_data` is 0x00.
- R9: The code is frozen even if `dbin` is low at the start of the acknowledge. If `dbin` rises later in that same acknowledge, the byte driven is the one for the level pending when `inta` rose.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_n | input | 8 | Active-low request lines; bit index is the priority level |
| inta | input | 1 | Interrupt acknowledge from the processor |
| dbin | input | 1 | Data-bus-in strobe; processor is reading the bus |
| int_req | output | 1 | Active-high interrupt to the processor |
| vec_data | output | 8 | RESTART opcode while enabled, else 0x00 |
| vec_oe | output | 1 | Bus enable for `vec_data` |

## Verification
The hardest case to reach from the ports is a request whose level differs from the one being served, arriving after acknowledge has started. This matters most when `dbin` is still low, because the frozen code cannot then be seen at the bus. The stimulus raises `inta` with a low-priority request pending. It then pulls the top-priority line low and waits cycles for the request register to take it in. Only after that does it raise `dbin` and read the byte. A second acknowledge afterwards shows that the new level was seen and simply not allowed into the earlier byte.

// File: rtl/rstvec_pkg.sv
package rstvec_pkg;
  localparam int NUM_LEVELS = 8;
  localparam int CODE_W     = $clog2(NUM_LEVELS);
  localparam int BYTE_W     = 8;

  // opcode frame around the level code: 11 NNN 111
  localparam logic [1:0] OPC_HEAD = 2'b11;
  localparam logic [2:0] OPC_TAIL = 3'b111;

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [BYTE_W-1:0] byte_t;

  function automatic byte_t restart_byte(input code_t lvl);
    return {OPC_HEAD, lvl, OPC_TAIL};
  endfunction
endpackage

// File: rtl/rstvec_req_reg.sv
module rstvec_req_reg #(
  parameter int LEVELS = rstvec_pkg::NUM_LEVELS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LEVELS-1:0] req_n,
  output logic [LEVELS-1:0] pend
);
  always_ff @(posedge clk) begin
    if (!rst_n) pend <= '0;
    else        pend <= ~req_n;
  end
endmodule

// File: rtl/rstvec_prio.sv
module rstvec_prio #(
  parameter int LEVELS = rstvec_pkg::NUM_LEVELS,
  localparam int CW    = $clog2(LEVELS)
) (
  input  logic [LEVELS-1:0] pend,
  output logic              any,
  output logic [CW-1:0]     level
);
  logic [LEVELS-1:0] above;
  logic [LEVELS-1:0] win;

  assign above[LEVELS-1] = 1'b0;
  genvar g;
  generate
    for (g = LEVELS - 2; g >= 0; g--) begin : g_chain
      assign above[g] = above[g+1] | pend[g+1];
    end
    for (g = 0; g < LEVELS; g++) begin : g_win
      assign win[g] = pend[g] & ~above[g];
    end
  endgenerate

  always_comb begin
    level = '0;
    for (int i = 0; i < LEVELS; i++) begin
      if (win[i]) level = level | CW'(i);
    end
  end

  assign any = |pend;
endmodule

// File: rtl/rstvec_hold.sv
module rstvec_hold #(
  parameter int CW = rstvec_pkg::CODE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inta,
  input  logic [CW-1:0] level,
  output logic [CW-1:0] code
);
  logic          inta_q;
  logic [CW-1:0] held;
  logic          start;

  assign start = inta & ~inta_q;
  assign code  = start ? level : held;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inta_q <= 1'b0;
      held   <= '0;
    end else begin
      inta_q <= inta;
      if (start) held <= level;
    end
  end
endmodule

// File: rtl/rstvec_drive.sv
module rstvec_drive
  import rstvec_pkg::*;
(
  input  logic  inta,
  input  logic  dbin,
  input  code_t code,
  output logic  oe,
  output byte_t data
);
  assign oe   = inta & dbin;
  assign data = oe ? restart_byte(code) : '0;
endmodule

// File: rtl/rstvec_encoder.sv
module rstvec_encoder
  import rstvec_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] irq_n,
  input  logic       inta,
  input  logic       dbin,
  output logic       int_req,
  output logic [7:0] vec_data,
  output logic       vec_oe
);
  logic [NUM_LEVELS-1:0] pend;
  code_t                 level;
  code_t                 code;

  rstvec_req_reg #(.LEVELS(NUM_LEVELS)) u_req (
    .clk(clk), .rst_n(rst_n), .req_n(irq_n), .pend(pend)
  );

  rstvec_prio #(.LEVELS(NUM_LEVELS)) u_prio (
    .pend(pend), .any(int_req), .level(level)
  );

  rstvec_hold #(.CW(CODE_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .inta(inta), .level(level), .code(code)
  );

  rstvec_drive u_drive (
    .inta(inta), .dbin(dbin), .code(code), .oe(vec_oe), .data(vec_data)
  );
endmodule

// File: rtl/rstvec_encoder_chk.sv
module rstvec_encoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] irq_n,
  input logic       inta,
  input logic       dbin,
  input logic       int_req,
  input logic [7:0] vec_data,
  input logic       vec_oe
);
  assert_int_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(&irq_n) |-> int_req);

  assert_int_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(&irq_n) |-> !int_req);

  assert_byte_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
    vec_oe |-> (vec_data[7:6] == 2'b11) && (vec_data[2:0] == 3'b111));

  assert_oe_needs_both_R5: assert property (@(posedge clk) disable iff (!rst_n)
    vec_oe |-> inta && dbin);

  assert_idle_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_oe |-> vec_data == 8'h00);

  assert_byte_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && vec_oe && $past(vec_oe) && $past(inta) |-> $stable(vec_data));
endmodule

bind rstvec_encoder rstvec_encoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .inta(inta), .dbin(dbin),
  .int_req(int_req), .vec_data(vec_data), .vec_oe(vec_oe)
);

// File: tb/rstvec_encoder_tb.sv
module rstvec_encoder_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] irq_n;
  logic       inta;
  logic       dbin;
  logic       int_req;
  logic [7:0] vec_data;
  logic       vec_oe;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  rstvec_encoder u_dut (
    .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .inta(inta), .dbin(dbin),
    .int_req(int_req), .vec_data(vec_data), .vec_oe(vec_oe)
  );

  // {irq_n, expected int_req, expected byte}
  localparam int NV = 11;
  localparam logic [16:0] VEC [NV] = '{
    {8'hFF, 1'b0, 8'hC7},
    {8'hFE, 1'b1, 8'hC7},
    {8'h7F, 1'b1, 8'hFF},
    {8'hF7, 1'b1, 8'hDF},
    {8'hAA, 1'b1, 8'hF7},
    {8'h55, 1'b1, 8'hFF},
    {8'hEF, 1'b1, 8'hE7},
    {8'hFD, 1'b1, 8'hCF},
    {8'hFB, 1'b1, 8'hD7},
    {8'hDF, 1'b1, 8'hEF},
    {8'h00, 1'b1, 8'hFF}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; irq_n = 8'h00; inta = 1'b0; dbin = 1'b1;
    repeat (3) @(negedge clk);
    // R8 reset state, requests pending and dbin high
    chk("R8 int", {7'b0, int_req}, 8'h00);
    chk("R8 oe", {7'b0, vec_oe}, 8'h00);
    chk("R8 data", vec_data, 8'h00);
    rst_n = 1'b1; irq_n = 8'hFF; dbin = 1'b0;
    @(negedge clk);

    // table walk: R1 R2 R3 R4 R5
    for (int k = 0; k < NV; k++) begin
      irq_n = VEC[k][16:9]; inta = 1'b0; dbin = 1'b0;
      @(negedge clk);
      #1;
      chk(VEC[k][8] ? "R1 int" : "R2 int", {7'b0, int_req}, {7'b0, VEC[k][8]});
      inta = 1'b1; dbin = 1'b1;
      #1;
      chk("R5 oe", {7'b0, vec_oe}, 8'h01);
      chk("R3/R4 byte", vec_data, VEC[k][7:0]);
      @(negedge clk);
      #1;
      chk("R4 held byte", vec_data, VEC[k][7:0]);
      inta = 1'b0; dbin = 1'b0;
      #1;
      chk("R6 off", vec_data, 8'h00);
    end

    // R6: dbin alone does not drive
    irq_n = 8'h7F; dbin = 1'b1; inta = 1'b0;
    @(negedge clk); #1;
    chk("R6 dbin only oe", {7'b0, vec_oe}, 8'h00);
    chk("R6 dbin only data", vec_data, 8'h00);

    // R7: new higher request during acknowledge
    dbin = 1'b0; irq_n = 8'hFB;
    @(negedge clk);
    inta = 1'b1; dbin = 1'b1; #1;
    chk("R7 start", vec_data, 8'hD7);
    irq_n = 8'h7B;
    repeat (2) begin
      @(negedge clk); #1;
      chk("R7 frozen", vec_data, 8'hD7);
    end
    inta = 1'b0; dbin = 1'b0;
    @(negedge clk);
    inta = 1'b1; dbin = 1'b1; #1;
    chk("R7 next ack", vec_data, 8'hFF);
    inta = 1'b0; dbin = 1'b0;

    // R9: dbin late within acknowledge
    irq_n = 8'hEF;
    @(negedge clk);
    inta = 1'b1; #1;
    chk("R5 no dbin oe", {7'b0, vec_oe}, 8'h00);
    chk("R6 no dbin data", vec_data, 8'h00);
    irq_n = 8'h6F;
    repeat (2) @(negedge clk);
    dbin = 1'b1; #1;
    chk("R9 late dbin", vec_data, 8'hE7);
    chk("R1 int during ack", {7'b0, int_req}, 8'h01);
    inta = 1'b0; dbin = 1'b0;
    @(negedge clk);

    finish_run();
  end
endmodule